// File: doc/BRIEF.md
# Separable Six-Tap Luma Interpolation Engine

This block forms fractional-sample luma predictions for motion compensation, one macroblock at a time. Before a run, the integer reference pixels for the whole macroblock are written into a local store through a simple write port. The store holds a 21x21 region, which is the 16x16 macroblock widened by two pixels above and to the left and three pixels below and to the right. A quarter-sample phase is then written for each of the sixteen 4x4 blocks, and a start pulse launches the run.

For each 4x4 block the engine passes nine window rows through one hardwired six-tap filter and keeps the unrounded row sums. It then reuses that same filter for the vertical work. This covers a column of integer pixels or a column of stored row sums, and it never needs more than two filter operations per output pixel. Quarter positions are built as rounded averages of neighbouring integer or half samples. A block with an integer phase skips the filter and copies pixels at one per cycle.

Results stream out as labelled pixels, and a one-cycle done flag marks the last one. Motion compensation logic upstream loads the store. The prediction consumer downstream collects the labelled pixels.

Top module: `qpel_interp`

## Requirements
- R1: After reset, busy, out_valid and done are low, and every stored block phase is integer.
- R2: Block phase is written as ph_frac = {yf[1:0], xf[1:0]} for block index ph_blk. Pixel (x,y) of the 21x21 store sits at address y*21+x, and the integer sample G of output pixel (px,py) in block b is at x = 4*b[1:0]+px+2, y = 4*b[3:2]+py+2. Phase 0000 outputs G unchanged.
- R3: A half position in one direction only (xf=2,yf=0 or xf=0,yf=2) outputs clip((S+16)>>5). S is the filter over the six pixels at offsets -2..+3 with weights 1,-5,20,20,-5,1, and the clip is to 0..255.
- R4: The centre position (xf=2,yf=2) filters the six unrounded horizontal sums of rows -2..+3 vertically and outputs clip((S+512)>>10).
- R5: Every other fractional phase outputs the rounded average (a+b+1)>>1 of the two nearest integer or half samples. When xf=3 the right-hand neighbours are used, and when yf=3 the lower neighbours are used.
- R6: Outputs appear in block order 0..15 and in raster order within a block. Each output is labelled by out_blk and out_pix = {py,px}.
- R7: done pulses for exactly one cycle together with the last pixel, and busy is low in that cycle. A full macroblock completes within 1280 cycles of start.
- R8: A macroblock whose sixteen phases are all integer completes within 256 cycles of start.
- R9: While busy, pixel writes, phase writes and start pulses have no effect on the current run or on later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_we | input | 1 | Reference pixel write strobe |
| pix_addr | input | 9 | Reference pixel address y*21+x |
| pix_data | input | 8 | Reference pixel value |
| ph_we | input | 1 | Block phase write strobe |
| ph_blk | input | 4 | Block index for phase write |
| ph_frac | input | 4 | Phase {yf,xf} in quarter samples |
| start | input | 1 | Launch a macroblock run |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Output pixel valid |
| out_blk | output | 4 | Block index of output pixel |
| out_pix | output | 4 | Pixel index {py,px} within the block |
| out_data | output | 8 | Interpolated pixel |
| done | output | 1 | Last pixel of the run |

## Verification
Two events can land in the same cycle: the engine emitting a pixel, and a store update or new start arriving on the load ports. The bench provokes this by writing a reference pixel, rewriting a block phase and pulsing start in the middle of a fractional run. Every output is then judged against expectations built from the unchanged data. A second run without any reload must produce the same results. The last pixel and done also coincide, and the bench checks that both appear in the same sampled cycle with busy already low.

// File: rtl/qpel_pkg.sv
`timescale 1ns/1ps
package qpel_pkg;
    localparam int BLK     = 4;                      // block edge
    localparam int TAPS    = 6;                      // filter length
    localparam int PRE     = 2;                      // pixels before the sample
    localparam int MB      = 16;                     // macroblock edge
    localparam int WIN     = BLK + TAPS - 1;         // window edge per block
    localparam int REF_W   = MB + TAPS - 1;          // store edge
    localparam int REF_N   = REF_W * REF_W;
    localparam int BPR     = MB / BLK;               // blocks per row
    localparam int NBLK    = BPR * BPR;
    localparam int REF_AW  = $clog2(REF_N);
    localparam int BLK_AW  = $clog2(NBLK);
    localparam int PIX_AW  = $clog2(BLK * BLK);
    localparam int CW      = $clog2(BLK);
    localparam int RW      = $clog2(WIN);
    localparam int BCW     = $clog2(BPR);
    localparam int IW      = 16;                     // row-sum width
    localparam int SW      = 24;                     // filter sum width
    localparam int NRD     = TAPS + 3;               // store read ports
    localparam int MB_BUDGET = 1280;

    typedef struct packed {
        logic [1:0] yf;
        logic [1:0] xf;
    } qphase_t;

    typedef enum logic [1:0] {S_IDLE, S_ROW, S_COL, S_COPY} qstate_t;

    function automatic qstate_t entry_state(input qphase_t p);
        return (p == '0) ? S_COPY : S_ROW;
    endfunction

    function automatic logic [7:0] round_clip(input logic signed [SW-1:0] s, input int sh);
        logic signed [SW-1:0] t;
        t = s + $signed(SW'(1) << (sh - 1));
        t = t >>> sh;
        if (t < 0)        return 8'd0;
        else if (t > 255) return 8'd255;
        else              return t[7:0];
    endfunction

    function automatic logic [7:0] avg2(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] t;
        t = {1'b0, a} + {1'b0, b} + 9'd1;
        return t[8:1];
    endfunction

    // g: integer, r: right integer, d: lower integer, b/s: horizontal half
    // on this/next row, v: vertical half on chosen column, j: centre
    function automatic logic [7:0] qpick(input qphase_t p,
        input logic [7:0] g, input logic [7:0] r, input logic [7:0] d,
        input logic [7:0] b, input logic [7:0] s, input logic [7:0] v,
        input logic [7:0] j);
        case ({p.yf, p.xf})
            4'b0000: return g;
            4'b0001: return avg2(g, b);
            4'b0010: return b;
            4'b0011: return avg2(r, b);
            4'b0100: return avg2(g, v);
            4'b0101: return avg2(b, v);
            4'b0110: return avg2(b, j);
            4'b0111: return avg2(b, v);
            4'b1000: return v;
            4'b1001: return avg2(v, j);
            4'b1010: return j;
            4'b1011: return avg2(v, j);
            4'b1100: return avg2(d, v);
            4'b1101: return avg2(v, s);
            4'b1110: return avg2(j, s);
            default: return avg2(v, s);
        endcase
    endfunction
endpackage

// File: rtl/qpel_sixtap.sv
`timescale 1ns/1ps
module qpel_sixtap
    import qpel_pkg::*;
(
    input  logic signed [IW-1:0] din [TAPS],
    output logic signed [SW-1:0] sum
);
    logic signed [SW-1:0] pr [TAPS/2];

    // symmetric taps: pair outer, middle and inner samples first
    for (genvar k = 0; k < TAPS/2; k++) begin : g_pair
        assign pr[k] = SW'(din[k]) + SW'(din[TAPS-1-k]);
    end

    // weights 1, -5, 20 by shift and add only
    assign sum = pr[0] - ((pr[1] <<< 2) + pr[1]) + ((pr[2] <<< 4) + (pr[2] <<< 2));
endmodule

// File: rtl/qpel_refbuf.sv
`timescale 1ns/1ps
module qpel_refbuf #(
    parameter int N   = 441,
    parameter int AW  = 9,
    parameter int NRD = 9,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    // storage is not reset: every run is preceded by a load
    logic [DW-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (we && (waddr < AW'(N))) mem[waddr] <= wdata;
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata[i] = (raddr[i] < AW'(N)) ? mem[raddr[i]] : '0;
    end
endmodule

// File: rtl/qpel_interp.sv
`timescale 1ns/1ps
module qpel_interp
    import qpel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_we,
    input  logic [REF_AW-1:0] pix_addr,
    input  logic [7:0]        pix_data,
    input  logic              ph_we,
    input  logic [BLK_AW-1:0] ph_blk,
    input  logic [3:0]        ph_frac,
    input  logic              start,
    output logic              busy,
    output logic              out_valid,
    output logic [BLK_AW-1:0] out_blk,
    output logic [PIX_AW-1:0] out_pix,
    output logic [7:0]        out_data,
    output logic              done
);
    qstate_t              state;
    logic [BLK_AW-1:0]    blk;
    logic [RW-1:0]        rr;
    logic [CW-1:0]        cc;
    logic [PIX_AW-1:0]    pix;
    logic                 sub;
    logic signed [SW-1:0] vtmp;
    logic signed [IW-1:0] rsum [WIN][BLK];
    qphase_t              phs [NBLK];

    qphase_t              cur;
    int                   ox, oy, px, py;
    logic [REF_AW-1:0]    raddr [NRD];
    logic [7:0]           rdata [NRD];
    logic signed [IW-1:0] fin [TAPS];
    logic signed [SW-1:0] fsum;
    logic [7:0]           pick;
    logic                 last_pix, last_blk;
    logic [BLK_AW-1:0]    nxt_blk;
    qstate_t              after_px;
    logic                 idle;

    assign idle = (state == S_IDLE);
    assign busy = !idle;

    qpel_refbuf #(.N(REF_N), .AW(REF_AW), .NRD(NRD), .DW(8)) u_buf (
        .clk   (clk),
        .we    (pix_we && idle),
        .waddr (pix_addr),
        .wdata (pix_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    qpel_sixtap u_tap (.din(fin), .sum(fsum));

    always_comb begin
        cur = phs[blk];
        ox  = int'(blk[BCW-1:0]) * BLK;
        oy  = int'(blk[BLK_AW-1:BCW]) * BLK;
        px  = int'(pix[CW-1:0]);
        py  = int'(pix[PIX_AW-1:CW]);
        for (int k = 0; k < TAPS; k++) begin
            case (state)
                S_ROW:   raddr[k] = REF_AW'((oy + int'(rr)) * REF_W + ox + int'(cc) + k);
                S_COL:   raddr[k] = REF_AW'((oy + py + k) * REF_W + ox + px + PRE
                                            + ((cur.xf == 2'd3) ? 1 : 0));
                default: raddr[k] = '0;
            endcase
            // second column step feeds the stored row sums back in
            fin[k] = (state == S_COL && sub) ? rsum[py + k][px]
                                              : $signed({{(IW-8){1'b0}}, rdata[k]});
        end
        raddr[TAPS]   = REF_AW'((oy + py + PRE) * REF_W + ox + px + PRE);
        raddr[TAPS+1] = REF_AW'((oy + py + PRE) * REF_W + ox + px + PRE + 1);
        raddr[TAPS+2] = REF_AW'((oy + py + PRE + 1) * REF_W + ox + px + PRE);
        pick = qpick(cur, rdata[TAPS], rdata[TAPS+1], rdata[TAPS+2],
                     round_clip(SW'(rsum[py + PRE][px]), 5),
                     round_clip(SW'(rsum[py + PRE + 1][px]), 5),
                     round_clip(vtmp, 5), round_clip(fsum, 10));
        last_pix = (pix == PIX_AW'(BLK * BLK - 1));
        last_blk = (blk == BLK_AW'(NBLK - 1));
        nxt_blk  = blk + 1'b1;
        after_px = !last_pix ? state : (last_blk ? S_IDLE : entry_state(phs[nxt_blk]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) phs[i] <= '0;
        end else if (ph_we && idle) begin
            phs[ph_blk] <= qphase_t'(ph_frac);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            blk       <= '0;
            rr        <= '0;
            cc        <= '0;
            pix       <= '0;
            sub       <= 1'b0;
            vtmp      <= '0;
            out_valid <= 1'b0;
            out_blk   <= '0;
            out_pix   <= '0;
            out_data  <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    blk   <= '0;
                    pix   <= '0;
                    rr    <= '0;
                    cc    <= '0;
                    sub   <= 1'b0;
                    state <= entry_state(phs[0]);
                end
                S_ROW: begin
                    rsum[rr][cc] <= fsum[IW-1:0];
                    if (cc == CW'(BLK - 1)) begin
                        cc <= '0;
                        if (rr == RW'(WIN - 1)) begin
                            rr    <= '0;
                            state <= S_COL;
                        end else begin
                            rr <= rr + 1'b1;
                        end
                    end else begin
                        cc <= cc + 1'b1;
                    end
                end
                S_COL, S_COPY: begin
                    if (state == S_COL && !sub) begin
                        vtmp <= fsum;
                        sub  <= 1'b1;
                    end else begin
                        sub       <= 1'b0;
                        out_valid <= 1'b1;
                        out_data  <= (state == S_COPY) ? rdata[TAPS] : pick;
                        out_blk   <= blk;
                        out_pix   <= pix;
                        pix       <= pix + 1'b1;
                        state     <= after_px;
                        if (last_pix && !last_blk) blk  <= nxt_blk;
                        if (last_pix && last_blk)  done <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qpel_interp_chk.sv
`timescale 1ns/1ps
module qpel_interp_chk
    import qpel_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              out_valid,
    input logic [BLK_AW-1:0] out_blk,
    input logic              done
);
    int unsigned       run_cyc;
    logic [BLK_AW-1:0] last_blk;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cyc <= 0;
        else              run_cyc <= run_cyc + 1;
    end

    always_ff @(posedge clk) begin
        if (rst || (!busy && !out_valid) || (start && !busy)) last_blk <= '0;
        else if (out_valid)                                   last_blk <= out_blk;
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    a_r7_done_idle:  assert property (@(posedge clk) disable iff (rst) done |-> !busy);
    a_r7_budget:     assert property (@(posedge clk) disable iff (rst) busy |-> (run_cyc < MB_BUDGET));
    a_r6_valid_run:  assert property (@(posedge clk) disable iff (rst) out_valid |-> (busy || done));
    a_r6_blk_order:  assert property (@(posedge clk) disable iff (rst) out_valid |-> (out_blk >= last_blk));
    a_r7_done_last:  assert property (@(posedge clk) disable iff (rst) done |-> (out_valid && out_blk == BLK_AW'(NBLK - 1)));
endmodule

bind qpel_interp qpel_interp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .out_valid (out_valid),
    .out_blk   (out_blk),
    .done      (done)
);

// File: tb/qpel_interp_bench.sv
`timescale 1ns/1ps
module qpel_interp_bench;
    import qpel_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_we = 1'b0;
    logic [REF_AW-1:0] pix_addr = '0;
    logic [7:0]        pix_data = '0;
    logic              ph_we = 1'b0;
    logic [BLK_AW-1:0] ph_blk = '0;
    logic [3:0]        ph_frac = '0;
    logic              start = 1'b0;
    logic              busy, out_valid, done;
    logic [BLK_AW-1:0] out_blk;
    logic [PIX_AW-1:0] out_pix;
    logic [7:0]        out_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int seed = 32'h1234_5678;

    logic [7:0] img [REF_N];
    logic [3:0] ph  [NBLK];
    int         expq [$];

    always #2.5 clk = ~clk;

    qpel_interp u_qpel_interp (
        .clk(clk), .rst(rst), .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .ph_we(ph_we), .ph_blk(ph_blk), .ph_frac(ph_frac), .start(start),
        .busy(busy), .out_valid(out_valid), .out_blk(out_blk), .out_pix(out_pix),
        .out_data(out_data), .done(done)
    );

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    function automatic int P(int x, int y);
        return int'(img[y * REF_W + x]);
    endfunction
    function automatic int hs(int x, int y);
        return P(x-2,y) - 5*P(x-1,y) + 20*P(x,y) + 20*P(x+1,y) - 5*P(x+2,y) + P(x+3,y);
    endfunction
    function automatic int vs(int x, int y);
        return P(x,y-2) - 5*P(x,y-1) + 20*P(x,y) + 20*P(x,y+1) - 5*P(x,y+2) + P(x,y+3);
    endfunction
    function automatic int js(int x, int y);
        return hs(x,y-2) - 5*hs(x,y-1) + 20*hs(x,y) + 20*hs(x,y+1) - 5*hs(x,y+2) + hs(x,y+3);
    endfunction
    function automatic int clipr(int s, int sh);
        int t;
        t = (s + (1 << (sh - 1))) >>> sh;
        return (t < 0) ? 0 : ((t > 255) ? 255 : t);
    endfunction
    function automatic int av(int a, int b);
        return (a + b + 1) >> 1;
    endfunction

    function automatic int expect_pix(int b, int p);
        int X, Y, xf, yf, g, r, d, hb, hsn, v, j;
        X  = 4 * (b % 4) + (p % 4) + 2;
        Y  = 4 * (b / 4) + (p / 4) + 2;
        xf = int'(ph[b][1:0]);
        yf = int'(ph[b][3:2]);
        g  = P(X, Y);  r = P(X + 1, Y);  d = P(X, Y + 1);
        hb  = clipr(hs(X, Y), 5);
        hsn = clipr(hs(X, Y + 1), 5);
        v  = clipr(vs((xf == 3) ? X + 1 : X, Y), 5);
        j  = clipr(js(X, Y), 10);
        case (yf * 4 + xf)
            0:  return g;
            1:  return av(g, hb);
            2:  return hb;
            3:  return av(r, hb);
            4:  return av(g, v);
            5, 7: return av(hb, v);
            6:  return av(hb, j);
            8:  return v;
            9, 11: return av(v, j);
            10: return j;
            12: return av(d, v);
            14: return av(j, hsn);
            default: return av(v, hsn);
        endcase
    endfunction

    function automatic string tag_of(int b);
        int xf, yf;
        xf = int'(ph[b][1:0]);
        yf = int'(ph[b][3:2]);
        if (xf == 0 && yf == 0) return "R2";
        if (xf == 2 && yf == 2) return "R4";
        if ((xf == 2 && yf == 0) || (xf == 0 && yf == 2)) return "R3";
        return "R5";
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_all();
        for (int a = 0; a < REF_N; a++) begin
            @(negedge clk); pix_we = 1'b1; pix_addr = REF_AW'(a); pix_data = img[a];
        end
        @(negedge clk); pix_we = 1'b0;
        for (int b = 0; b < NBLK; b++) begin
            @(negedge clk); ph_we = 1'b1; ph_blk = BLK_AW'(b); ph_frac = ph[b];
        end
        @(negedge clk); ph_we = 1'b0;
    endtask

    // driver: pushes expectations, launches, optionally disturbs the run
    task automatic run_mb(int limit, string req, bit noise);
        int cnt;
        for (int b = 0; b < NBLK; b++)
            for (int p = 0; p < BLK * BLK; p++)
                expq.push_back((b << 12) | (p << 8) | expect_pix(b, p));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cnt = 0;
        while (!done && cnt < 5000) begin
            @(negedge clk);
            cnt++;
            if (noise) begin
                // R9: writes and start while busy
                pix_we = (cnt == 5); pix_addr = REF_AW'(100); pix_data = ~img[100];
                ph_we  = (cnt == 6); ph_blk = BLK_AW'(3); ph_frac = ~ph[3];
                start  = (cnt == 7);
            end
        end
        pix_we = 1'b0; ph_we = 1'b0; start = 1'b0;
        check(cnt <= limit, req, cnt, limit);
        check(busy == 1'b0, "R7 busy low after done", int'(busy), 0);
        @(negedge clk);
        check(expq.size() == 0, "R6 all pixels emitted", expq.size(), 0);
        expq.delete();
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int got, exp, b;
            got = (int'(out_blk) << 12) | (int'(out_pix) << 8) | int'(out_data);
            if (expq.size() == 0) begin
                check(1'b0, "R6 unexpected pixel", got, -1);
            end else begin
                exp = expq.pop_front();
                b = exp >> 12;
                checks++;
                if (got != exp) begin
                    fails++;
                    $display("FAIL %s R6 blk %0d pix %0d: actual %h expected %h",
                             tag_of(b), b, (exp >> 8) & 15, got, exp);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0,      "R1 busy",      int'(busy), 0);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(done == 1'b0,      "R1 done",      int'(done), 0);
        // R1: phases reset to integer, store loaded, phases not written
        for (int a = 0; a < REF_N; a++) img[a] = 8'(rnd());
        for (int b = 0; b < NBLK; b++) ph[b] = 4'd0;
        for (int a = 0; a < REF_N; a++) begin
            @(negedge clk); pix_we = 1'b1; pix_addr = REF_AW'(a); pix_data = img[a];
        end
        @(negedge clk); pix_we = 1'b0;
        run_mb(256, "R8 R1 integer run latency", 1'b0);

        // every phase once, random picture
        for (int b = 0; b < NBLK; b++) ph[b] = 4'(b);
        load_all();
        run_mb(MB_BUDGET, "R7 mixed phase latency", 1'b0);

        // clipping extremes: checkerboard
        for (int a = 0; a < REF_N; a++) img[a] = (((a % REF_W) + (a / REF_W)) % 2 == 1) ? 8'd255 : 8'd0;
        for (int b = 0; b < NBLK; b++) ph[b] = 4'((b * 7) % 16);
        load_all();
        run_mb(MB_BUDGET, "R7 checkerboard latency", 1'b0);

        // all centre positions on a stripe picture
        for (int a = 0; a < REF_N; a++) img[a] = ((a / REF_W) % 3 == 0) ? 8'd250 : 8'd3;
        for (int b = 0; b < NBLK; b++) ph[b] = 4'b1010;
        load_all();
        run_mb(MB_BUDGET, "R4 centre run latency", 1'b0);

        // all integer phases: short path
        for (int a = 0; a < REF_N; a++) img[a] = 8'(rnd());
        for (int b = 0; b < NBLK; b++) ph[b] = 4'd0;
        load_all();
        run_mb(256, "R8 integer run latency", 1'b0);

        // disturbed run, then a clean repeat with no reload
        for (int b = 0; b < NBLK; b++) ph[b] = 4'(rnd() % 15 + 1);
        load_all();
        run_mb(MB_BUDGET, "R9 disturbed run latency", 1'b1);
        run_mb(MB_BUDGET, "R9 repeat run latency", 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule